// File: doc/BRIEF.md
# Byte-Mask Load/Store Conflict Detector

This block keeps a small set of load/store address slots and reports, for every pair of live slots, whether the two accesses may touch the same memory bytes. A scheduler uses the matrix to decide which memory operations can go ahead in parallel. Two accesses that may share a byte must be serialised. The check is deliberately approximate. High address bits are never compared, so false conflicts are allowed. A real overlap must never be missed.

Each slot has a set strobe, a release strobe, an address and a two-bit access size. On a set strobe the slot becomes live. It then stores a partial tag from address bits TAG_HI:TAG_LO and a byte-occupancy bitmap over a window of 2^TAG_LO bytes. The bitmap is a contiguous run of ones whose length follows the access size and which starts at the offset given by the address bits below TAG_LO. Two live slots conflict when their tags are equal and their bitmaps share a bit. An access that runs past the top of its window is also checked against the next window. The matrix is computed combinationally from the registered slot state.

Top module: `ls_conflict_det`

## Requirements
- R1: While reset is asserted, and after it is released with no set strobe seen, every slot is invalid and the whole conflict matrix is zero.
- R2: A set strobe on slot k makes it valid and captures its address and size at that clock edge. A release strobe alone makes it invalid. When set and release are both high, set wins. The matrix reflects the new state from the cycle after the edge.
- R3: Diagonal bit k*N+k of the matrix is always 0.
- R4: A matrix bit i*N+j is 1 only when slots i and j are both valid. Once a slot is released, its row and column are zero.
- R5: The tag is address bits 11:4 by default. Address bits above the tag never affect the result. Two non-crossing accesses whose tags differ do not conflict.
- R6: Size code 0, 1, 2 and 3 marks 1, 2, 4 and 8 bytes respectively. These are contiguous bitmap bits starting at bit position addr[3:0] of the 16-bit bitmap.
- R7: Two valid slots with equal tags conflict if and only if their bitmaps share at least one set bit, or the crossing rule of R8 applies.
- R8: An access is crossing when offset plus byte count exceeds 16. A crossing slot conflicts with every other valid slot whose tag equals its own tag, or equals its own tag plus one modulo 2^8. The rule applies in both directions of the pair.
- R9: A slot's captured tag and bitmap do not change without a set strobe. Changing its address or size inputs otherwise has no effect on the matrix.
- R10: The matrix is symmetric: bit i*N+j equals bit j*N+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | N | Per-slot set strobe: capture address and size, mark valid |
| rel_i | input | N | Per-slot release strobe: mark invalid |
| addr_i | input | N*ADDR_W | Slot addresses, slot k at bits k*ADDR_W +: ADDR_W |
| size_i | input | 2*N | Slot access size codes, slot k at bits 2k +: 2 |
| conflict_o | output | N*N | Conflict matrix, bit i*N+j set when slots i and j may overlap |

## Verification
Directed patterns come first, and each one separates a single piece of the matching rule. The first pair shares a tag and overlaps only in bytes. The second shares a tag but has disjoint bitmaps. The third differs only in high bits that must be ignored. The fourth differs in tag by one, which only the crossing rule can turn into a conflict, including the wrap from the top tag to zero. Set-with-release and address changes without a set show whether slot state is captured only on the set strobe. Random traffic then draws tags from a small pool next to a boundary, with random offsets and sizes. This mixes overlapping, disjoint and crossing pairs across every slot combination, and the whole matrix is compared against a model each cycle.

// File: rtl/ls_conf_pkg.sv
package ls_conf_pkg;
  // Access size encodings, byte count is 1 << code
  typedef enum logic [1:0] {
    ACC_B1 = 2'd0,
    ACC_B2 = 2'd1,
    ACC_B4 = 2'd2,
    ACC_B8 = 2'd3
  } acc_size_e;

  function automatic int unsigned size_bytes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/ls_byte_mask.sv
module ls_byte_mask
  import ls_conf_pkg::*;
#(
  parameter int WIN   = 16,
  parameter int OFF_W = 4
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [WIN-1:0]   mask_o,
  output logic             cross_o
);
  localparam int SPAN_W = 2 * WIN;

  logic [WIN-1:0]    run;
  logic [SPAN_W-1:0] span;
  int unsigned       nbytes;

  always_comb begin
    nbytes = size_bytes(size_i);
    for (int b = 0; b < WIN; b++) begin
      run[b] = (b < nbytes);
    end
    span    = {{WIN{1'b0}}, run} << off_i;
    mask_o  = span[WIN-1:0];
    cross_o = |span[SPAN_W-1:WIN];
  end
endmodule

// File: rtl/ls_slot_reg.sv
module ls_slot_reg #(
  parameter int TAG_W = 8,
  parameter int WIN   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             rel_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [WIN-1:0]   mask_i,
  input  logic             cross_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [WIN-1:0]   mask_o,
  output logic             cross_o
);
  logic             valid_d;
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [WIN-1:0]   mask_q;
  logic             cross_q;

  // next state: set has priority over release
  always_comb begin
    valid_d = valid_q;
    if (set_i) begin
      valid_d = 1'b1;
    end else if (rel_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // captured fields, clock enable is the set strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      mask_q  <= '0;
      cross_q <= 1'b0;
    end else if (set_i) begin
      tag_q   <= tag_i;
      mask_q  <= mask_i;
      cross_q <= cross_i;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign mask_o  = mask_q;
  assign cross_o = cross_q;
endmodule

// File: rtl/ls_pair_cmp.sv
module ls_pair_cmp #(
  parameter int TAG_W = 8,
  parameter int WIN   = 16
) (
  input  logic             va_i,
  input  logic             vb_i,
  input  logic [TAG_W-1:0] tag_a_i,
  input  logic [TAG_W-1:0] tag_b_i,
  input  logic [WIN-1:0]   mask_a_i,
  input  logic [WIN-1:0]   mask_b_i,
  input  logic             cross_a_i,
  input  logic             cross_b_i,
  output logic             hit_o
);
  logic             tag_eq;
  logic             b_next_of_a;
  logic             a_next_of_b;
  logic             byte_ovl;
  logic [TAG_W-1:0] tag_a_inc;
  logic [TAG_W-1:0] tag_b_inc;

  always_comb begin
    tag_a_inc   = tag_a_i + 1'b1;
    tag_b_inc   = tag_b_i + 1'b1;
    tag_eq      = (tag_a_i == tag_b_i);
    b_next_of_a = (tag_b_i == tag_a_inc);
    a_next_of_b = (tag_a_i == tag_b_inc);
    byte_ovl    = |(mask_a_i & mask_b_i);
    hit_o = va_i && vb_i &&
            ((tag_eq && byte_ovl) ||
             (cross_a_i && (tag_eq || b_next_of_a)) ||
             (cross_b_i && (tag_eq || a_next_of_b)));
  end
endmodule

// File: rtl/ls_conflict_det.sv
module ls_conflict_det #(
  parameter int N      = 4,
  parameter int ADDR_W = 64,
  parameter int TAG_LO = 4,
  parameter int TAG_HI = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        set_i,
  input  logic [N-1:0]        rel_i,
  input  logic [N*ADDR_W-1:0] addr_i,
  input  logic [2*N-1:0]      size_i,
  output logic [N*N-1:0]      conflict_o
);
  localparam int TAG_W = TAG_HI - TAG_LO + 1;
  localparam int WIN   = 1 << TAG_LO;
  localparam int OFF_W = TAG_LO;

  logic [N-1:0]       slot_valid;
  logic [N*TAG_W-1:0] slot_tag_flat;
  logic [N*WIN-1:0]   slot_mask_flat;
  logic [N-1:0]       slot_cross;
  logic [N*WIN-1:0]   new_mask_flat;
  logic [N-1:0]       new_cross;

  for (genvar k = 0; k < N; k++) begin : g_slot
    logic [ADDR_W-1:0] a;
    assign a = addr_i[k*ADDR_W +: ADDR_W];

    ls_byte_mask #(.WIN(WIN), .OFF_W(OFF_W)) u_mask (
      .off_i  (a[OFF_W-1:0]),
      .size_i (size_i[2*k +: 2]),
      .mask_o (new_mask_flat[k*WIN +: WIN]),
      .cross_o(new_cross[k])
    );

    ls_slot_reg #(.TAG_W(TAG_W), .WIN(WIN)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_i[k]),
      .rel_i  (rel_i[k]),
      .tag_i  (a[TAG_HI:TAG_LO]),
      .mask_i (new_mask_flat[k*WIN +: WIN]),
      .cross_i(new_cross[k]),
      .valid_o(slot_valid[k]),
      .tag_o  (slot_tag_flat[k*TAG_W +: TAG_W]),
      .mask_o (slot_mask_flat[k*WIN +: WIN]),
      .cross_o(slot_cross[k])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_self
        assign conflict_o[i*N+j] = 1'b0;
      end else begin : g_pair
        ls_pair_cmp #(.TAG_W(TAG_W), .WIN(WIN)) u_cmp (
          .va_i     (slot_valid[i]),
          .vb_i     (slot_valid[j]),
          .tag_a_i  (slot_tag_flat[i*TAG_W +: TAG_W]),
          .tag_b_i  (slot_tag_flat[j*TAG_W +: TAG_W]),
          .mask_a_i (slot_mask_flat[i*WIN +: WIN]),
          .mask_b_i (slot_mask_flat[j*WIN +: WIN]),
          .cross_a_i(slot_cross[i]),
          .cross_b_i(slot_cross[j]),
          .hit_o    (conflict_o[i*N+j])
        );
      end
    end
  end
endmodule

// File: rtl/ls_conflict_det_chk.sv
module ls_conflict_det_chk #(
  parameter int N     = 4,
  parameter int TAG_W = 8,
  parameter int WIN   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0]       set_i,
  input logic [N-1:0]       rel_i,
  input logic [2*N-1:0]     size_i,
  input logic [N*N-1:0]     conflict_o,
  input logic [N-1:0]       valid_q,
  input logic [N*TAG_W-1:0] tag_q,
  input logic [N*WIN-1:0]   new_mask,
  input logic [N-1:0]       new_cross
);
  for (genvar i = 0; i < N; i++) begin : g_i
    // R3
    diag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_o[i*N+i] == 1'b0);

    // R6
    mask_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !new_cross[i] |-> ($countones(new_mask[i*WIN +: WIN]) == (1 << size_i[2*i +: 2])));

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> valid_q[i]);

    // R9
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i[i] |=> $stable(tag_q[i*TAG_W +: TAG_W]));

    for (genvar j = 0; j < N; j++) begin : g_j
      // R10
      symmetric_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o[i*N+j] == conflict_o[j*N+i]);

      // R4
      valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q[i] |-> !conflict_o[i*N+j]);

      // R4
      released_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i[i] && !set_i[i]) |=> !conflict_o[i*N+j]);
    end
  end
endmodule

bind ls_conflict_det ls_conflict_det_chk #(
  .N    (N),
  .TAG_W(TAG_HI - TAG_LO + 1),
  .WIN  (1 << TAG_LO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_i     (set_i),
  .rel_i     (rel_i),
  .size_i    (size_i),
  .conflict_o(conflict_o),
  .valid_q   (slot_valid),
  .tag_q     (slot_tag_flat),
  .new_mask  (new_mask_flat),
  .new_cross (new_cross)
);

// File: tb/sim_ls_conflict_det.sv
`timescale 1ns/1ps
module sim_ls_conflict_det;
  localparam int N  = 4;
  localparam int AW = 64;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    set_i;
  logic [N-1:0]    rel_i;
  logic [N*AW-1:0] addr_i;
  logic [2*N-1:0]  size_i;
  logic [N*N-1:0]  conflict_o;

  ls_conflict_det #(.N(N), .ADDR_W(AW), .TAG_LO(4), .TAG_HI(11)) u0 (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .rel_i(rel_i),
    .addr_i(addr_i), .size_i(size_i), .conflict_o(conflict_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model of slot state
  logic       mv[N];
  logic [7:0] mt[N];
  logic [3:0] mo[N];
  logic [1:0] ms[N];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  function automatic logic [31:0] span(input logic [3:0] off, input logic [1:0] sz);
    return ((32'd1 << (32'd1 << sz)) - 32'd1) << off;
  endfunction

  function automatic logic exp_bit(input int i, input int j);
    logic [31:0] si, sj;
    logic ci, cj, teq, ovl;
    if (i == j || !mv[i] || !mv[j]) return 1'b0;
    si  = span(mo[i], ms[i]);
    sj  = span(mo[j], ms[j]);
    ci  = |si[31:16];
    cj  = |sj[31:16];
    teq = (mt[i] == mt[j]);
    ovl = |(si[15:0] & sj[15:0]);
    return (teq && ovl) || (ci && (teq || mt[j] == 8'(mt[i] + 8'd1)))
                        || (cj && (teq || mt[i] == 8'(mt[j] + 8'd1)));
  endfunction

  function automatic logic [N*N-1:0] exp_mat();
    logic [N*N-1:0] m;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        m[i*N+j] = exp_bit(i, j);
    return m;
  endfunction

  task automatic check_mat(input string req);
    logic [N*N-1:0] e;
    e = exp_mat();
    checks++;
    if (conflict_o !== e) begin
      errors++;
      $display("FAIL %s: conflict matrix actual %h expected %h", req, conflict_o, e);
    end
  endtask

  task automatic put(input int k, input logic [63:0] a, input logic [1:0] sz);
    set_i[k] = 1'b1;
    addr_i[k*AW +: AW] = a;
    size_i[2*k +: 2] = sz;
  endtask

  // one clock: model follows the strobes at the edge, then outputs are sampled
  task automatic cyc();
    @(posedge clk);
    for (int k = 0; k < N; k++) begin
      if (set_i[k]) begin
        mv[k] = 1'b1;
        mt[k] = addr_i[k*AW+4 +: 8];
        mo[k] = addr_i[k*AW +: 4];
        ms[k] = size_i[2*k +: 2];
      end else if (rel_i[k]) begin
        mv[k] = 1'b0;
      end
    end
    @(negedge clk);
    set_i = '0;
    rel_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; set_i = '0; rel_i = '0; addr_i = '0; size_i = '0;
    for (int k = 0; k < N; k++) begin mv[k] = 0; mt[k] = 0; mo[k] = 0; ms[k] = 0; end
    repeat (3) @(negedge clk);
    check_mat("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_mat("R1 after reset");

    // R7 same tag, overlapping bytes
    put(0, 64'h100, 2'd0); put(1, 64'h100, 2'd3); cyc();
    check_mat("R7 overlap");
    // R7 same tag, disjoint bytes
    put(1, 64'h101, 2'd0); cyc();
    check_mat("R7 disjoint");
    // R6 misaligned word 0x106..0x109 against byte at 0x109
    put(0, 64'h106, 2'd2); put(1, 64'h109, 2'd0); cyc();
    check_mat("R6 misaligned run");
    // R5 upper bits differ only
    put(0, 64'hABC0_0000_0000_0130, 2'd1); put(1, 64'h0000_0000_0000_0130, 2'd0); cyc();
    check_mat("R5 upper ignored");
    // R5 different tag, no crossing
    put(1, 64'h140, 2'd3); cyc();
    check_mat("R5 tag differs");
    // R8 crossing dword into next window
    put(0, 64'h13C, 2'd3); put(1, 64'h14F, 2'd0); cyc();
    check_mat("R8 crossing");
    // R8 wrap of the tag
    put(2, 64'hFFE, 2'd2); put(3, 64'h00F, 2'd0); cyc();
    check_mat("R8 tag wrap");
    // R2 set and release together
    rel_i[3] = 1'b1; put(3, 64'h00E, 2'd0); cyc();
    check_mat("R2 set beats release");
    // R9 address change without set
    addr_i = {N{64'h0000_0000_0000_0555}}; size_i = '1; cyc();
    check_mat("R9 hold");
    // R4 release clears
    rel_i = 4'b0101; cyc();
    check_mat("R4 release");
    rel_i = '1; cyc();
    check_mat("R4 all released");

    // random traffic around a tag boundary
    for (int c = 0; c < 3000; c++) begin
      for (int k = 0; k < N; k++) begin
        int r;
        logic [7:0] t;
        logic [63:0] a;
        r = int'($urandom % 8);
        case ($urandom % 5)
          0: t = 8'h20; 1: t = 8'h21; 2: t = 8'h22; 3: t = 8'hFF; default: t = 8'h00;
        endcase
        a = {$urandom, $urandom};
        a[11:4] = t;
        if (r < 3) begin
          put(k, a, 2'($urandom));
        end else begin
          addr_i[k*AW +: AW] = a;
          size_i[2*k +: 2] = 2'($urandom);
          if (r == 3) rel_i[k] = 1'b1;
          if (r == 4) begin rel_i[k] = 1'b1; set_i[k] = 1'b1; end
        end
      end
      cyc();
      check_mat("R7/R8/R10 random");
    end
    finish_run();
  end
endmodule